// File: doc/BRIEF.md
# CSR Access Instruction Controller

This block turns one decoded control-and-status-register instruction into the strobes a CSR file needs. It accepts the three-bit function code, the destination index, the five-bit source field (a register index or an immediate), the source register value, the current register-width mode and the fetch address. One cycle later it presents a read strobe, a write strobe, write data and a write mask. Read-write, read-set and read-clear are all expressed as one masked write: the CSR file only has to apply the mask.

The CSR file returns the old value in the same cycle the strobes are presented. The block merges that old value with the registered data and mask to give the new value. It sends the old value to the register file when the destination is not the zero register. It also raises a flush with the address of the next sequential instruction, so that fetch restarts after any state the access may have changed.

The decision to skip a read or a write is taken from register indices only. A source register that holds zero still causes a write.

Top module: `csr_access_ctl`

## Requirements
- R1: The function code selects the operation. Its low two bits give the kind: 01 read-write, 10 set, 11 clear. Bit 2 set selects the immediate form. Codes 000 and 100 produce no read strobe, no write strobe, no write-back and no flush.
- R2: A read-write with destination index 0 raises the write strobe but not the read strobe.
- R3: A set or clear with source field 0 raises the read strobe but not the write strobe.
- R4: A set or clear whose source field is nonzero raises the write strobe even when the source value is zero. The mask is then zero.
- R5: Set drives write data of all ones. The mask is the source register value, or the zero-extended five-bit field in the immediate form.
- R6: Clear drives write data of all zeros. The mask comes from the same source as for set.
- R7: Read-write uses a mask of all ones, or only the low 32 bits in 32-bit mode. Its write data is the source register value, or the zero-extended field in the immediate form.
- R8: In 32-bit mode, register-sourced data and masks keep only their low 32 bits.
- R9: Every legal access raises the flush. The redirect address is the fetch address plus 4, or plus 2 for a short instruction. In 32-bit mode the redirect address keeps only its low 32 bits.
- R10: Register write-back is raised exactly when a legal access has a nonzero destination index. The write-back data is the old CSR value.
- R11: The new CSR value is (old AND NOT mask) OR (data AND mask) while the write strobe is high.
- R12: After reset all strobes are low. Strobes are high only in the cycle after an accepted instruction and fall when no instruction is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction offered this cycle |
| funct3_i | input | 3 | Function code |
| rd_idx_i | input | 5 | Destination register index |
| rs1_fld_i | input | 5 | Source register index or immediate |
| rs1_val_i | input | XLEN | Source register value |
| mode32_i | input | 1 | 32-bit register width mode |
| pc_i | input | XLEN | Fetch address of the instruction |
| short_insn_i | input | 1 | Instruction is two bytes long |
| csr_old_i | input | XLEN | Old CSR value from the CSR file |
| csr_rd_en_o | output | 1 | CSR read strobe |
| csr_wr_en_o | output | 1 | CSR write strobe |
| csr_wdata_o | output | XLEN | Write data |
| csr_wmask_o | output | XLEN | Write mask |
| csr_new_o | output | XLEN | Merged new CSR value |
| rf_we_o | output | 1 | Register write-back enable |
| rf_wdata_o | output | XLEN | Register write-back data |
| flush_o | output | 1 | Pipeline flush request |
| redirect_pc_o | output | XLEN | Refetch address |

## Verification
The sweep tries all eight function codes. For each it uses destination indices 0, 5 and 31, and source fields 0, 1, 19 and 31. Source values of zero, a mixed pattern and one with the top and bottom bits set are paired with each. Every combination runs in both width modes. A zero destination with a read-write separates R2 from the set and clear forms. A zero field against a nonzero field holding zero separates index-based suppression from value-based suppression (R3, R4). The 32-bit runs, with source values whose upper half is nonzero, show whether masks and data are truncated. A fetch address just below a 32-bit boundary, with both instruction lengths, exposes missing wrap in the redirect address.

// File: rtl/csr_ctl_pkg.sv
package csr_ctl_pkg;
  typedef enum logic [1:0] {
    CSR_K_NONE = 2'b00,
    CSR_K_RW   = 2'b01,
    CSR_K_SET  = 2'b10,
    CSR_K_CLR  = 2'b11
  } csr_kind_e;

  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned FN_W      = 3;
  localparam int unsigned NARROW_W  = 32;
  localparam int unsigned LEN_FULL  = 4;
  localparam int unsigned LEN_SHORT = 2;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_ctl_pkg::*;
(
  input  logic [FN_W-1:0]      funct3_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  input  logic [REG_IDX_W-1:0] rs1_fld_i,
  output csr_kind_e            kind_o,
  output logic                 use_imm_o,
  output logic                 legal_o,
  output logic                 do_read_o,
  output logic                 do_write_o,
  output logic                 do_wb_o
);
  logic rd_nz;
  logic fld_nz;

  always_comb begin
    kind_o     = csr_kind_e'(funct3_i[1:0]);
    use_imm_o  = funct3_i[2];
    legal_o    = (kind_o != CSR_K_NONE);
    rd_nz      = (rd_idx_i != '0);
    fld_nz     = (rs1_fld_i != '0);
    do_read_o  = 1'b0;
    do_write_o = 1'b0;
    unique case (kind_o)
      CSR_K_RW: begin
        do_read_o  = rd_nz;
        do_write_o = 1'b1;
      end
      CSR_K_SET, CSR_K_CLR: begin
        do_read_o  = 1'b1;
        do_write_o = fld_nz;
      end
      default: begin
        do_read_o  = 1'b0;
        do_write_o = 1'b0;
      end
    endcase
    do_wb_o = legal_o && rd_nz;
  end
endmodule

// File: rtl/csr_operand_gen.sv
module csr_operand_gen
  import csr_ctl_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  csr_kind_e            kind_i,
  input  logic                 use_imm_i,
  input  logic                 mode32_i,
  input  logic [REG_IDX_W-1:0] rs1_fld_i,
  input  logic [XLEN-1:0]      rs1_val_i,
  output logic [XLEN-1:0]      wdata_o,
  output logic [XLEN-1:0]      wmask_o
);
  localparam int unsigned PAD_W = XLEN - REG_IDX_W;

  logic [XLEN-1:0] width_mask;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] src_raw;
  logic [XLEN-1:0] src_fit;

  generate
    if (XLEN > NARROW_W) begin : g_wide
      always_comb begin
        if (mode32_i) width_mask = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        else          width_mask = {XLEN{1'b1}};
      end
    end else begin : g_narrow
      always_comb begin
        width_mask = {XLEN{1'b1}};
      end
      logic unused_mode;
      assign unused_mode = mode32_i;
    end
  endgenerate

  always_comb begin
    imm_ext = {{PAD_W{1'b0}}, rs1_fld_i};
    src_raw = use_imm_i ? imm_ext : rs1_val_i;
    src_fit = src_raw & width_mask;
    unique case (kind_i)
      CSR_K_RW: begin
        wdata_o = src_fit;
        wmask_o = width_mask;
      end
      CSR_K_SET: begin
        wdata_o = {XLEN{1'b1}};
        wmask_o = src_fit;
      end
      CSR_K_CLR: begin
        wdata_o = '0;
        wmask_o = src_fit;
      end
      default: begin
        wdata_o = '0;
        wmask_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/csr_merge.sv
module csr_merge #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [XLEN-1:0] mask_i,
  output logic [XLEN-1:0] new_o
);
  always_comb begin
    new_o = (old_i & ~mask_i) | (data_i & mask_i);
  end
endmodule

// File: rtl/csr_access_ctl.sv
module csr_access_ctl
  import csr_ctl_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [FN_W-1:0]      funct3_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  input  logic [REG_IDX_W-1:0] rs1_fld_i,
  input  logic [XLEN-1:0]      rs1_val_i,
  input  logic                 mode32_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic                 short_insn_i,
  input  logic [XLEN-1:0]      csr_old_i,
  output logic                 csr_rd_en_o,
  output logic                 csr_wr_en_o,
  output logic [XLEN-1:0]      csr_wdata_o,
  output logic [XLEN-1:0]      csr_wmask_o,
  output logic [XLEN-1:0]      csr_new_o,
  output logic                 rf_we_o,
  output logic [XLEN-1:0]      rf_wdata_o,
  output logic                 flush_o,
  output logic [XLEN-1:0]      redirect_pc_o
);
  csr_kind_e       kind;
  logic            use_imm;
  logic            legal;
  logic            do_read;
  logic            do_write;
  logic            do_wb;
  logic [XLEN-1:0] op_wdata;
  logic [XLEN-1:0] op_wmask;
  logic [XLEN-1:0] next_pc_raw;
  logic [XLEN-1:0] next_pc;

  logic            fire;
  logic            rd_en_d, rd_en_q;
  logic            wr_en_d, wr_en_q;
  logic            wb_d, wb_q;
  logic            flush_d, flush_q;
  logic [XLEN-1:0] wdata_q, wmask_q, redir_q;

  csr_op_decode u_dec (
    .funct3_i   (funct3_i),
    .rd_idx_i   (rd_idx_i),
    .rs1_fld_i  (rs1_fld_i),
    .kind_o     (kind),
    .use_imm_o  (use_imm),
    .legal_o    (legal),
    .do_read_o  (do_read),
    .do_write_o (do_write),
    .do_wb_o    (do_wb)
  );

  csr_operand_gen #(.XLEN(XLEN)) u_opnd (
    .kind_i    (kind),
    .use_imm_i (use_imm),
    .mode32_i  (mode32_i),
    .rs1_fld_i (rs1_fld_i),
    .rs1_val_i (rs1_val_i),
    .wdata_o   (op_wdata),
    .wmask_o   (op_wmask)
  );

  always_comb begin
    next_pc_raw = pc_i + (short_insn_i ? XLEN'(LEN_SHORT) : XLEN'(LEN_FULL));
  end

  generate
    if (XLEN > NARROW_W) begin : g_pc_wide
      always_comb begin
        next_pc = next_pc_raw;
        if (mode32_i) next_pc[XLEN-1:NARROW_W] = '0;
      end
    end else begin : g_pc_narrow
      always_comb begin
        next_pc = next_pc_raw;
      end
    end
  endgenerate

  // next-state
  always_comb begin
    fire    = valid_i && legal;
    rd_en_d = fire && do_read;
    wr_en_d = fire && do_write;
    wb_d    = fire && do_wb;
    flush_d = fire;
  end

  // strobes: updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      wb_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      rd_en_q <= rd_en_d;
      wr_en_q <= wr_en_d;
      wb_q    <= wb_d;
      flush_q <= flush_d;
    end
  end

  // operands: loaded only when an access is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      wmask_q <= '0;
      redir_q <= '0;
    end else if (fire) begin
      wdata_q <= op_wdata;
      wmask_q <= op_wmask;
      redir_q <= next_pc;
    end
  end

  csr_merge #(.XLEN(XLEN)) u_merge (
    .old_i  (csr_old_i),
    .data_i (wdata_q),
    .mask_i (wmask_q),
    .new_o  (csr_new_o)
  );

  assign csr_rd_en_o   = rd_en_q;
  assign csr_wr_en_o   = wr_en_q;
  assign csr_wdata_o   = wdata_q;
  assign csr_wmask_o   = wmask_q;
  assign rf_we_o       = wb_q;
  assign rf_wdata_o    = wb_q ? csr_old_i : '0;
  assign flush_o       = flush_q;
  assign redirect_pc_o = redir_q;
endmodule

// File: rtl/csr_access_chk.sv
module csr_access_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [2:0]      funct3_i,
  input logic [4:0]      rd_idx_i,
  input logic [4:0]      rs1_fld_i,
  input logic [XLEN-1:0] csr_old_i,
  input logic            csr_rd_en_o,
  input logic            csr_wr_en_o,
  input logic [XLEN-1:0] csr_wdata_o,
  input logic [XLEN-1:0] csr_wmask_o,
  input logic [XLEN-1:0] csr_new_o,
  input logic            rf_we_o,
  input logic            flush_o
);
  p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && funct3_i[1:0] == 2'b00) |=> (!csr_rd_en_o && !csr_wr_en_o && !flush_o && !rf_we_o));

  p_rw_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && funct3_i[1:0] == 2'b01 && rd_idx_i == 5'd0) |=> (!csr_rd_en_o && csr_wr_en_o));

  p_setclr_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && funct3_i[1] && rs1_fld_i == 5'd0) |=> (csr_rd_en_o && !csr_wr_en_o));

  p_set_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && funct3_i[1:0] == 2'b10) |=> (csr_wdata_o == {XLEN{1'b1}}));

  p_clear_zeros_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && funct3_i[1:0] == 2'b11) |=> (csr_wdata_o == '0));

  p_access_flushes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_en_o || csr_wr_en_o) |-> flush_o);

  p_wb_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> csr_rd_en_o);

  p_unmasked_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en_o |-> (((csr_new_o ^ csr_old_i) & ~csr_wmask_o) == '0));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!flush_o && !csr_rd_en_o && !csr_wr_en_o));
endmodule

bind csr_access_ctl csr_access_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .funct3_i    (funct3_i),
  .rd_idx_i    (rd_idx_i),
  .rs1_fld_i   (rs1_fld_i),
  .csr_old_i   (csr_old_i),
  .csr_rd_en_o (csr_rd_en_o),
  .csr_wr_en_o (csr_wr_en_o),
  .csr_wdata_o (csr_wdata_o),
  .csr_wmask_o (csr_wmask_o),
  .csr_new_o   (csr_new_o),
  .rf_we_o     (rf_we_o),
  .flush_o     (flush_o)
);

// File: tb/sim_csr_access_ctl.sv
`timescale 1ns/1ps
module sim_csr_access_ctl;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid_i;
  logic [2:0]    funct3_i;
  logic [4:0]    rd_idx_i;
  logic [4:0]    rs1_fld_i;
  logic [XL-1:0] rs1_val_i;
  logic          mode32_i;
  logic [XL-1:0] pc_i;
  logic          short_insn_i;
  logic [XL-1:0] csr_old_i;
  logic          csr_rd_en_o, csr_wr_en_o, rf_we_o, flush_o;
  logic [XL-1:0] csr_wdata_o, csr_wmask_o, csr_new_o, rf_wdata_o, redirect_pc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  csr_access_ctl #(.XLEN(XL)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .funct3_i(funct3_i),
    .rd_idx_i(rd_idx_i), .rs1_fld_i(rs1_fld_i), .rs1_val_i(rs1_val_i),
    .mode32_i(mode32_i), .pc_i(pc_i), .short_insn_i(short_insn_i),
    .csr_old_i(csr_old_i), .csr_rd_en_o(csr_rd_en_o), .csr_wr_en_o(csr_wr_en_o),
    .csr_wdata_o(csr_wdata_o), .csr_wmask_o(csr_wmask_o), .csr_new_o(csr_new_o),
    .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .flush_o(flush_o),
    .redirect_pc_o(redirect_pc_o)
  );

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  function automatic logic [XL-1:0] val_pat(input int i);
    case (i)
      0:       return '0;
      1:       return 64'hA5C3_0F12_3456_789B;
      default: return 64'h8000_0000_8000_0001;
    endcase
  endfunction

  function automatic logic [4:0] rd_pat(input int i);
    case (i)
      0:       return 5'd0;
      1:       return 5'd5;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic [4:0] fld_pat(input int i);
    case (i)
      0:       return 5'd0;
      1:       return 5'd1;
      2:       return 5'd19;
      default: return 5'd31;
    endcase
  endfunction

  initial begin
    logic [XL-1:0] lo32, src, e_d, e_m, e_pc, old;
    logic legal, e_rd, e_wr, e_wb;
    string t_m, t_d;
    int op_n;
    rst_n = 1'b0; valid_i = 0; funct3_i = 0; rd_idx_i = 0; rs1_fld_i = 0;
    rs1_val_i = 0; mode32_i = 0; pc_i = 0; short_insn_i = 0; csr_old_i = 0;
    repeat (3) @(posedge clk);
    #2;
    // R12: reset state
    chk("R12 rd_en after reset", XL'(csr_rd_en_o), 0);
    chk("R12 wr_en after reset", XL'(csr_wr_en_o), 0);
    chk("R12 flush after reset", XL'(flush_o), 0);
    chk("R12 rf_we after reset", XL'(rf_we_o), 0);
    @(negedge clk) rst_n = 1'b1;
    lo32 = 64'h0000_0000_FFFF_FFFF;
    op_n = 0;
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 3; r++)
        for (int fi = 0; fi < 4; fi++)
          for (int vi = 0; vi < 3; vi++)
            for (int m = 0; m < 2; m++) begin
              op_n++;
              old = 64'h1234_5678_9ABC_DEF0 ^ (XL'(op_n) * 64'h9E37_79B9_7F4A_7C15);
              @(negedge clk);
              valid_i = 1; funct3_i = 3'(f); rd_idx_i = rd_pat(r);
              rs1_fld_i = fld_pat(fi); rs1_val_i = val_pat(vi); mode32_i = m[0];
              short_insn_i = op_n[0];
              pc_i = (op_n % 3 == 0) ? 64'h0000_0001_FFFF_FFFE : 64'h0000_0000_0000_1000 + XL'(op_n * 4);
              csr_old_i = old;
              // expected values
              legal = (f[1:0] != 2'b00);
              src = f[2] ? {59'd0, rs1_fld_i} : rs1_val_i;
              if (m == 1) src = src & lo32;
              case (f[1:0])
                2'b01: begin
                  e_rd = (rd_idx_i != 0); e_wr = 1;
                  e_d = src; e_m = (m == 1) ? lo32 : '1;
                  t_d = "R7 rw data"; t_m = "R7 rw mask";
                end
                2'b10: begin
                  e_rd = 1; e_wr = (rs1_fld_i != 0);
                  e_d = '1; e_m = src;
                  t_d = "R5 set data"; t_m = (m == 1 && !f[2]) ? "R8 set mask 32" : "R5 set mask";
                end
                2'b11: begin
                  e_rd = 1; e_wr = (rs1_fld_i != 0);
                  e_d = '0; e_m = src;
                  t_d = "R6 clear data"; t_m = (m == 1 && !f[2]) ? "R8 clear mask 32" : "R6 clear mask";
                end
                default: begin
                  e_rd = 0; e_wr = 0; e_d = '0; e_m = '0;
                  t_d = "R1"; t_m = "R1";
                end
              endcase
              e_wb = legal && (rd_idx_i != 0);
              e_pc = pc_i + (short_insn_i ? 64'd2 : 64'd4);
              if (m == 1) e_pc = e_pc & lo32;
              @(posedge clk);
              #2;
              if (!legal) begin
                chk("R1 rd_en illegal", XL'(csr_rd_en_o), 0);
                chk("R1 wr_en illegal", XL'(csr_wr_en_o), 0);
                chk("R1 flush illegal", XL'(flush_o), 0);
                chk("R1 rf_we illegal", XL'(rf_we_o), 0);
              end else begin
                chk(f[1:0] == 2'b01 ? "R2 read strobe" : "R3 read strobe", XL'(csr_rd_en_o), XL'(e_rd));
                chk((rs1_fld_i != 0 && rs1_val_i == 0) ? "R4 write strobe zero value" :
                    (f[1:0] == 2'b01 ? "R2 write strobe" : "R3 write strobe"),
                    XL'(csr_wr_en_o), XL'(e_wr));
                chk("R10 rf_we", XL'(rf_we_o), XL'(e_wb));
                chk("R9 flush", XL'(flush_o), 1);
                chk("R9 redirect", redirect_pc_o, e_pc);
                if (e_wr) begin
                  chk(t_d, csr_wdata_o, e_d);
                  chk(t_m, csr_wmask_o, e_m);
                  chk("R11 new value", csr_new_o, (old & ~e_m) | (e_d & e_m));
                end
                if (e_wb) chk("R10 rf data", rf_wdata_o, old);
              end
              @(negedge clk);
              valid_i = 0;
              @(posedge clk);
              #2;
              chk("R12 idle strobes", XL'({csr_rd_en_o, csr_wr_en_o, flush_o, rf_we_o}), 0);
            end
    finish_run();
  end
endmodule